// File: doc/BRIEF.md
# Framed Serial Angle Readout Port

This block is a read-only, three-wire serial port that lets a host read a 12-bit absolute angle from a tracking counter. The host drives an active-low chip select and a serial clock. Both come from outside the chip and are sampled in a faster system clock domain. The port drives one serial data line. That line is shared with other ports on the same bus, so it is modelled as a data value plus an output enable that stands for the tristate control.

When chip select falls, the port takes a snapshot of the live angle. Each falling serial-clock edge after that presents the next bit, most significant bit first. Twelve pulses deliver the whole word, and pulses beyond the twelfth deliver zeros. Releasing chip select drops the output enable.

Two timing rules protect the frame. Falling serial-clock edges that arrive too soon after chip select falls are ignored. A chip-select fall that follows too short a high period does not open a frame.

Top module: `angle_serial_port`

## Requirements
- R1: Out of reset, `data_oe_o` is 0 and `data_o` is 0.
- R2: Whenever `data_oe_o` is 0, `data_o` is 0. A rising edge on `cs_ni` during an open frame clears `data_oe_o` three system clock edges later.
- R3: An accepted falling edge on `cs_ni` sets `data_oe_o` to 1 three system clock edges later. `data_o` is 0 until the first honoured serial-clock fall.
- R4: The k-th honoured falling edge of `sclk_i` (k = 1..12) puts bit 12-k of the angle on `data_o`, so bit 11 (the MSB) comes first and bit 0 comes last. Rising edges of `sclk_i` leave `data_o` unchanged.
- R5: The word sent is the value of `angle_i` at the accepted fall of `cs_ni`. Changes to `angle_i` later in the frame do not affect it.
- R6: Every honoured falling edge of `sclk_i` after the twelfth in a frame puts 0 on `data_o`.
- R7: Edges on `sclk_i` while no frame is open leave `data_oe_o` at 0 and do not alter the bits of the next frame.
- R8: Falling edges of `sclk_i` detected within SETTLE_CYC system cycles after a frame opens are ignored. `data_o` stays 0, and the next honoured fall still presents the MSB.
- R9: A falling edge of `cs_ni` that follows a synchronised high period shorter than CS_HIGH_MIN+1 system cycles is rejected. `data_oe_o` stays 0 for that whole low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select, asynchronous |
| sclk_i | input | 1 | Serial clock from the host, idles high, asynchronous |
| angle_i | input | 12 | Live angle from the tracking counter |
| data_o | output | 1 | Serial data value |
| data_oe_o | output | 1 | Drive enable for the data line (0 = high impedance) |

## Verification
Each edge on `cs_ni` or `sclk_i` passes through two synchroniser flops and one edge register, so its effect on `data_o` or `data_oe_o` appears at the third rising system clock edge after the input changes. The bench changes inputs just after a falling system edge and holds every serial-clock phase for five system cycles. It samples only at falling system edges, after the result is due and before the next input change can show up. Settle-window and short-high cases place the offending edge one or two cycles after the chip-select change, well inside the window, so that the outcome does not depend on the exact sampling cycle.

// File: rtl/asp_pkg.sv
package asp_pkg;
  typedef struct packed {
    logic start;  // accepted frame open
    logic stop;   // frame close
    logic shift;  // honoured serial-clock fall
  } frame_ctl_t;
endpackage

// File: rtl/asp_sync_edge.sv
module asp_sync_edge #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic lvl_o,
  output logic chg_o
);
  logic [STAGES-1:0] stg_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= RST_VAL;
      else if (i == 0) stg_q[i] <= async_i;
      else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign lvl_o = stg_q[STAGES-1];
  assign chg_o = stg_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/asp_frame_gate.sv
module asp_frame_gate
  import asp_pkg::*;
#(
  parameter int unsigned SETTLE_CYC  = 4,
  parameter int unsigned CS_HIGH_MIN = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_lvl_i,
  input  logic       cs_fall_i,
  input  logic       cs_rise_i,
  input  logic       sclk_fall_i,
  input  logic       active_i,
  output frame_ctl_t ctl_o
);
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1) > 0 ? $clog2(SETTLE_CYC + 1) : 1;
  localparam int unsigned HW = $clog2(CS_HIGH_MIN + 1) > 0 ? $clog2(CS_HIGH_MIN + 1) : 1;
  localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE_CYC);
  localparam logic [HW-1:0] HIGH_V   = HW'(CS_HIGH_MIN);

  logic [SW-1:0] settle_q;
  logic [HW-1:0] high_q;
  logic          high_ok;

  assign high_ok     = (high_q == HIGH_V);
  assign ctl_o.start = cs_fall_i & high_ok & ~active_i;
  assign ctl_o.stop  = cs_rise_i & active_i;
  assign ctl_o.shift = sclk_fall_i & active_i & (settle_q == '0) & ~cs_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               settle_q <= '0;
    else if (ctl_o.start)      settle_q <= SETTLE_V;
    else if (settle_q != '0)   settle_q <= settle_q - 1'b1;
  end

  // high-time counter, saturating; reset counts as a long idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         high_q <= HIGH_V;
    else if (cs_rise_i)                  high_q <= '0;
    else if (cs_lvl_i && !high_ok)       high_q <= high_q + 1'b1;
  end
endmodule

// File: rtl/asp_shifter.sv
module asp_shifter
  import asp_pkg::*;
#(
  parameter int unsigned ANGLE_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  frame_ctl_t         ctl_i,
  input  logic [ANGLE_W-1:0] angle_i,
  output logic               data_o,
  output logic               oe_o
);
  logic [ANGLE_W-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      data_o  <= 1'b0;
      oe_o    <= 1'b0;
    end else if (ctl_i.stop) begin
      data_o  <= 1'b0;
      oe_o    <= 1'b0;
    end else if (ctl_i.start) begin
      shreg_q <= angle_i;
      data_o  <= 1'b0;
      oe_o    <= 1'b1;
    end else if (ctl_i.shift) begin
      data_o  <= shreg_q[ANGLE_W-1];
      shreg_q <= {shreg_q[ANGLE_W-2:0], 1'b0};  // zero fill past the word
    end
  end
endmodule

// File: rtl/angle_serial_port.sv
module angle_serial_port
  import asp_pkg::*;
#(
  parameter int unsigned ANGLE_W     = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETTLE_CYC  = 4,
  parameter int unsigned CS_HIGH_MIN = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sclk_i,
  input  logic [ANGLE_W-1:0] angle_i,
  output logic               data_o,
  output logic               data_oe_o
);
  logic       cs_lvl, cs_chg, sclk_lvl, sclk_chg;
  logic       cs_fall, cs_rise, sclk_fall;
  frame_ctl_t ctl;

  asp_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk_i, .rst_ni, .async_i(cs_ni), .lvl_o(cs_lvl), .chg_o(cs_chg)
  );

  asp_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
    .clk_i, .rst_ni, .async_i(sclk_i), .lvl_o(sclk_lvl), .chg_o(sclk_chg)
  );

  assign cs_fall   = cs_chg & ~cs_lvl;
  assign cs_rise   = cs_chg & cs_lvl;
  assign sclk_fall = sclk_chg & ~sclk_lvl;

  asp_frame_gate #(.SETTLE_CYC(SETTLE_CYC), .CS_HIGH_MIN(CS_HIGH_MIN)) u_gate (
    .clk_i, .rst_ni,
    .cs_lvl_i(cs_lvl), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_fall_i(sclk_fall), .active_i(data_oe_o), .ctl_o(ctl)
  );

  asp_shifter #(.ANGLE_W(ANGLE_W)) u_shift (
    .clk_i, .rst_ni, .ctl_i(ctl), .angle_i,
    .data_o, .oe_o(data_oe_o)
  );
endmodule

// File: rtl/asp_checker.sv
module asp_checker #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic data_o,
  input logic data_oe_o,
  input logic cs_fall_i,
  input logic cs_rise_i,
  input logic sclk_fall_i
);
  localparam int unsigned AW = $clog2(SETTLE_CYC + 2);
  logic [AW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          age_q <= '0;
    else if (!data_oe_o)                  age_q <= '0;
    else if (age_q != AW'(SETTLE_CYC))    age_q <= age_q + 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i) !rst_ni |-> (!data_o && !data_oe_o));

  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> !data_o);

  assert_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> !data_oe_o);

  assert_open_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> (!data_o && $past(cs_fall_i)));

  assert_hold_between_falls_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && !sclk_fall_i && !cs_rise_i) |=> $stable(data_o));

  assert_idle_sclk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_oe_o && !cs_fall_i) |=> !data_oe_o);

  assert_settle_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && age_q < AW'(SETTLE_CYC) && sclk_fall_i && !cs_rise_i) |=> ($stable(data_o) && data_oe_o));
endmodule

bind angle_serial_port asp_checker #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .data_o(data_o), .data_oe_o(data_oe_o),
  .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .sclk_fall_i(sclk_fall)
);

// File: tb/sim_angle_serial_port.sv
`timescale 1ns/1ps
module sim_angle_serial_port;
  localparam int W = 12;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 1;
  logic [W-1:0] angle = '0;
  logic data, oe;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  angle_serial_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk),
    .angle_i(angle), .data_o(data), .data_oe_o(oe)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse();
    sclk = 0; wait_cyc(5);
    sclk = 1; wait_cyc(5);
  endtask

  task automatic open_frame();
    cs_n = 0; wait_cyc(12);
  endtask

  task automatic close_frame();
    cs_n = 1; wait_cyc(4);
    chk("R2 oe off", oe, 1'b0);
    chk("R2 data zero", data, 1'b0);
    wait_cyc(12);
  endtask

  // read n bits; bits past the word must be zero
  task automatic read_bits(input logic [W-1:0] exp_w, input int n, input string req);
    for (int k = 1; k <= n; k++) begin
      sclk = 0; wait_cyc(4);
      chk(req, data, (k <= W) ? exp_w[W-k] : 1'b0);
      wait_cyc(1);
      sclk = 1; wait_cyc(4);
      chk("R4 rise hold", data, (k <= W) ? exp_w[W-k] : 1'b0);
      wait_cyc(1);
    end
  endtask

  initial begin
    wait_cyc(3);
    chk("R1 oe", oe, 1'b0);
    chk("R1 data", data, 1'b0);
    rst_n = 1; wait_cyc(10);

    // R4 sweep over spread and corner angles
    for (int i = 0; i < 110; i++) begin
      logic [W-1:0] a;
      case (i)
        0: a = 12'h000; 1: a = 12'hFFF; 2: a = 12'h800; 3: a = 12'h001;
        4: a = 12'hAAA; 5: a = 12'h555;
        default: a = W'((i * 37 + i * i * 11) % 4096);
      endcase
      angle = a;
      cs_n = 0; wait_cyc(4);
      chk("R3 oe on", oe, 1'b1);
      chk("R3 data zero", data, 1'b0);
      wait_cyc(8);
      read_bits(a, W, "R4 bit");
      close_frame();
    end

    // R5 snapshot: angle changes mid frame
    angle = 12'hC3A;
    open_frame();
    read_bits(12'hC3A, 3, "R5 before change");
    angle = 12'h3C5;
    for (int k = 4; k <= W; k++) begin
      pulse();
      chk("R5 snapshot", data, 1'(12'hC3A >> (W - k)));
    end
    close_frame();

    // R6 extra pulses give zeros
    angle = 12'hFFF;
    open_frame();
    read_bits(12'hFFF, W + 4, "R6 overrun");
    close_frame();

    // R7 sclk toggling while idle
    for (int k = 0; k < 6; k++) begin
      pulse();
      chk("R7 idle oe", oe, 1'b0);
      chk("R7 idle data", data, 1'b0);
    end
    angle = 12'h9B1;
    open_frame();
    read_bits(12'h9B1, W, "R7 next frame");
    close_frame();

    // R8 fall inside the settle window
    angle = 12'hB00;
    cs_n = 0; wait_cyc(2);
    sclk = 0; wait_cyc(5);
    chk("R8 early fall ignored", data, 1'b0);
    chk("R8 oe", oe, 1'b1);
    sclk = 1; wait_cyc(6);
    read_bits(12'hB00, W, "R8 msb first");
    close_frame();

    // R9 short high between frames
    angle = 12'hFFF;
    open_frame();
    cs_n = 1; wait_cyc(2);
    cs_n = 0;
    for (int k = 0; k < 4; k++) begin
      wait_cyc(4);
      chk("R9 rejected oe", oe, 1'b0);
    end
    pulse();
    chk("R9 rejected data", data, 1'b0);
    close_frame();
    angle = 12'h801;
    open_frame();
    chk("R9 accepted after idle", oe, 1'b1);
    read_bits(12'h801, W, "R9 bit");
    close_frame();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule